// File: doc/BRIEF.md
# SAR Converter Serial Readout Sequencer

This block runs an 18-bit successive-approximation converter from the host side. Once the start enable is raised, it pulses the convert-start line at a fixed rate, waits out the converter's timing windows, and then clocks the serial result in with a burst of serial-clock pulses. Each finished word is handed on with a one-cycle valid strobe. All intervals are counted in system clock cycles and set by parameters. A combination of parameters that cannot place the burst, both quiet windows and the cycle period inside one period is rejected at elaboration.

Two modes are offered. In normal mode the burst waits until the conversion just started has finished, and it reads that conversion. In turbo mode the convert-start pulse is stretched to the first quiet window. The burst begins as soon as that window closes and reads the conversion started one period earlier, so that readout overlaps the running conversion. The mode is taken at the start of each period.

Top module: `sar_readout_ctrl`

## Requirements
- R1: A synchronous active-low reset drives `cnv`, `sck` and `word_valid` low from the cycle after reset is sampled low. No conversion starts while `enable` is low.
- R2: While `enable` is high, `cnv` rises every `CYC_PERIOD` cycles. When `enable` falls, the period in progress completes, including its readout, and `cnv` does not rise again.
- R3: `cnv` stays high for `CNV_HIGH` cycles in a normal period and for `QUIET1` cycles in a turbo period.
- R4: In a normal period, the first `sck` rise comes exactly `CONV_WAIT` cycles after `cnv` rises. The word delivered is the result of the conversion started by that rise.
- R5: In a turbo period, the first `sck` rise comes exactly `QUIET1` cycles after `cnv` rises. The word delivered is the result of the conversion started by the previous `cnv` rise.
- R6: A turbo period carries no readout (no `sck` pulse) unless the period directly before it was also a turbo period. This covers a start from idle, the period after a normal period, and the period after a reset.
- R7: Each readout is exactly `DATA_W` `sck` pulses. Each pulse is high for `SCK_HALF` cycles, with `SCK_HALF` low cycles between pulses. `sck` is low at all other times.
- R8: The last `sck` fall of a readout comes at least `QUIET2` cycles before the next `cnv` rise.
- R9: `sdo` is sampled on the clock edge at which `sck` rises. The first sampled bit becomes `word_data[DATA_W-1]` (most significant bit first) and the last becomes bit 0.
- R10: `word_valid` is high for exactly one cycle: the cycle in which `sck` is high for the `DATA_W`-th time. `word_data` holds its value until the next word.
- R11: `turbo` is sampled only at the edge where `cnv` rises. A change in the middle of a period takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Keep converting while high |
| turbo | input | 1 | 1 selects overlapped (turbo) readout for the next period |
| sdo | input | 1 | Serial result bit from the converter |
| cnv | output | 1 | Convert-start pulse to the converter |
| sck | output | 1 | Serial clock to the converter, idles low |
| word_valid | output | 1 | One-cycle strobe for a new word |
| word_data | output | DATA_W | Last captured result, MSB first on the wire |

## Verification
The bench targets the mode boundaries. These are a switch from normal to turbo in the middle of a period, a turbo start from idle, and a reset in the middle of a burst. A design that sampled `turbo` at the wrong moment would start the burst at the wrong offset. A design that read in the first turbo period would deliver a stale or missing word instead of skipping it. The data patterns include all-ones, all-zeros and alternating bits, so a bit-order or off-by-one shift error shows up as a wrong word or a late strobe. An enable drop in the middle of a period checks that the readout of that period still arrives and that `cnv` then stays low.

// File: rtl/sar_rd_pkg.sv
// Shared types and helpers for the SAR readout sequencer.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time constant functions.
package sar_rd_pkg;

    // Phase of the serial clock generator.
    typedef enum logic [1:0] {
        SCK_REST = 2'd0,
        SCK_HI   = 2'd1,
        SCK_LO   = 2'd2
    } sck_phase_e;

    // Cycles taken from a cnv rise to the point where the next cnv rise may come.
    function automatic int unsigned span_cycles(input int unsigned lead,
                                                input int unsigned bits,
                                                input int unsigned half,
                                                input int unsigned tail);
        return lead + 2 * bits * half + tail;
    endfunction

endpackage

// File: rtl/sar_cycle_timer.sv
// Period timer: counts the conversion period, shapes the cnv pulse and
// issues a one-cycle go the cycle before the first serial clock rise.
// Assumes: parameters already checked by the top; QUIET1 <= CONV_WAIT < CYC_PERIOD.
module sar_cycle_timer
    import sar_rd_pkg::*;
#(
    parameter int unsigned CYC_PERIOD = 125,
    parameter int unsigned CNV_HIGH   = 2,
    parameter int unsigned CONV_WAIT  = 40,
    parameter int unsigned QUIET1     = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic turbo,
    output logic cnv,
    output logic go,
    output logic mode
);

    localparam int unsigned CW = (CYC_PERIOD > 2) ? $clog2(CYC_PERIOD) : 1;
    localparam logic [CW-1:0] LAST_C  = CW'(CYC_PERIOD - 1);
    localparam logic [CW-1:0] HIGH_C  = CW'(CNV_HIGH);
    localparam logic [CW-1:0] Q1_C    = CW'(QUIET1);
    localparam logic [CW-1:0] Q1_GO_C = CW'(QUIET1 - 1);
    localparam logic [CW-1:0] NW_GO_C = CW'(CONV_WAIT - 1);

    logic          running_q, nxt_running;
    logic [CW-1:0] cnt_q, nxt_cnt;
    logic          mode_q, nxt_mode;
    logic          prev_q, nxt_prev;
    logic          cnv_q, go_q;
    logic          start_idle, wrap;
    logic [CW-1:0] go_at;

    // Next-state decode of the period counter, mode latch and overlap history.
    always_comb begin
        start_idle  = !running_q && enable;
        wrap        = running_q && (cnt_q == LAST_C);
        nxt_running = start_idle || (running_q && !(wrap && !enable));
        nxt_cnt     = cnt_q;
        nxt_mode    = mode_q;
        nxt_prev    = prev_q;
        if (start_idle || wrap) begin
            nxt_cnt  = '0;
            nxt_mode = turbo;
            nxt_prev = start_idle ? 1'b0 : (mode_q && enable);
        end else if (running_q) begin
            nxt_cnt = cnt_q + 1'b1;
        end
        go_at = nxt_mode ? Q1_GO_C : NW_GO_C;
    end

    // Register the period state and the registered cnv / go outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            mode_q    <= 1'b0;
            prev_q    <= 1'b0;
            cnv_q     <= 1'b0;
            go_q      <= 1'b0;
        end else begin
            running_q <= nxt_running;
            cnt_q     <= nxt_cnt;
            mode_q    <= nxt_mode;
            prev_q    <= nxt_prev;
            cnv_q     <= nxt_running && (nxt_cnt < (nxt_mode ? Q1_C : HIGH_C));
            go_q      <= nxt_running && (nxt_cnt == go_at) && (!nxt_mode || nxt_prev);
        end
    end

    assign cnv  = cnv_q;
    assign go   = go_q;
    assign mode = mode_q;

endmodule

// File: rtl/sar_sck_gen.sv
// Serial clock burst generator: on go emits DATA_W pulses of SCK_HALF high
// and SCK_HALF low cycles, and flags each clock edge at which sck rises.
// Assumes: go is only raised while the generator rests.
module sar_sck_gen
    import sar_rd_pkg::*;
#(
    parameter int unsigned DATA_W   = 18,
    parameter int unsigned SCK_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic sck,
    output logic sample
);

    localparam int unsigned HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int unsigned BW = $clog2(DATA_W + 1);
    localparam logic [HW-1:0] HLAST = HW'(SCK_HALF - 1);
    localparam logic [BW-1:0] BLAST = BW'(DATA_W);

    sck_phase_e    phase_q, nxt_phase;
    logic [HW-1:0] half_q, nxt_half;
    logic [BW-1:0] bits_q, nxt_bits;
    logic          sck_q;

    // Phase sequencing: rest -> (high -> low) x DATA_W -> rest.
    always_comb begin
        nxt_phase = phase_q;
        nxt_half  = half_q;
        nxt_bits  = bits_q;
        case (phase_q)
            SCK_REST: begin
                if (go) begin
                    nxt_phase = SCK_HI;
                    nxt_half  = '0;
                    nxt_bits  = '0;
                end
            end
            SCK_HI: begin
                if (half_q == HLAST) begin
                    nxt_phase = SCK_LO;
                    nxt_half  = '0;
                    nxt_bits  = bits_q + 1'b1;
                end else begin
                    nxt_half = half_q + 1'b1;
                end
            end
            SCK_LO: begin
                if (half_q == HLAST) begin
                    nxt_half  = '0;
                    nxt_phase = (bits_q == BLAST) ? SCK_REST : SCK_HI;
                end else begin
                    nxt_half = half_q + 1'b1;
                end
            end
            default: nxt_phase = SCK_REST;
        endcase
    end

    // Register the phase and a glitch-free serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SCK_REST;
            half_q  <= '0;
            bits_q  <= '0;
            sck_q   <= 1'b0;
        end else begin
            phase_q <= nxt_phase;
            half_q  <= nxt_half;
            bits_q  <= nxt_bits;
            sck_q   <= (nxt_phase == SCK_HI);
        end
    end

    assign sck    = sck_q;
    assign sample = (nxt_phase == SCK_HI) && (phase_q != SCK_HI);

endmodule

// File: rtl/sar_shift_capture.sv
// MSB-first shift capture: takes one bit per sample strobe and, on the
// DATA_W-th bit, loads the output word and strobes valid for one cycle.
// Assumes: sdo is already timed to the system clock; DATA_W >= 3.
module sar_shift_capture #(
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              sdo,
    output logic [DATA_W-1:0] word,
    output logic              valid
);

    localparam int unsigned NW = $clog2(DATA_W);
    localparam logic [NW-1:0] NLAST = NW'(DATA_W - 1);

    logic [DATA_W-2:0] shift_q;
    logic [NW-1:0]     cnt_q;
    logic [DATA_W-1:0] word_q;
    logic              valid_q;

    // Shift bits in and publish each complete word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (sample) begin
                if (cnt_q == NLAST) begin
                    word_q  <= {shift_q, sdo};
                    valid_q <= 1'b1;
                    cnt_q   <= '0;
                end else begin
                    shift_q <= {shift_q[DATA_W-3:0], sdo};
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign word  = word_q;
    assign valid = valid_q;

endmodule

// File: rtl/sar_readout_ctrl.sv
// Top of the SAR readout sequencer: period timer, serial clock burst and
// shift capture. Rejects at elaboration any parameter set whose burst and
// quiet windows do not fit inside one conversion period.
// Assumes: all intervals are given in system clock cycles, rounded up.
module sar_readout_ctrl
    import sar_rd_pkg::*;
#(
    parameter int unsigned DATA_W     = 18,
    parameter int unsigned CYC_PERIOD = 125,
    parameter int unsigned CNV_HIGH   = 2,
    parameter int unsigned CONV_WAIT  = 40,
    parameter int unsigned QUIET1     = 24,
    parameter int unsigned QUIET2     = 8,
    parameter int unsigned SCK_HALF   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              turbo,
    input  logic              sdo,
    output logic              cnv,
    output logic              sck,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data
);

    localparam int unsigned NORMAL_SPAN = span_cycles(CONV_WAIT, DATA_W, SCK_HALF, QUIET2);
    localparam int unsigned TURBO_SPAN  = span_cycles(QUIET1, DATA_W, SCK_HALF, QUIET2);
    localparam bit FITS = (NORMAL_SPAN <= CYC_PERIOD) && (TURBO_SPAN <= CYC_PERIOD)
                       && (CNV_HIGH >= 1) && (QUIET1 >= 2) && (QUIET1 <= CONV_WAIT)
                       && (CNV_HIGH < CONV_WAIT) && (SCK_HALF >= 1) && (DATA_W >= 3);

    // Refuse a parameter set that cannot hold both quiet windows and the burst.
    generate
        if (!FITS) begin : g_timing_reject
            $error("sar_readout_ctrl: burst plus quiet windows exceed the cycle period");
        end
    endgenerate

    logic tmr_go;
    logic tmr_mode;
    logic smp;

    sar_cycle_timer #(
        .CYC_PERIOD (CYC_PERIOD),
        .CNV_HIGH   (CNV_HIGH),
        .CONV_WAIT  (CONV_WAIT),
        .QUIET1     (QUIET1)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .turbo  (turbo),
        .cnv    (cnv),
        .go     (tmr_go),
        .mode   (tmr_mode)
    );

    sar_sck_gen #(
        .DATA_W   (DATA_W),
        .SCK_HALF (SCK_HALF)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (tmr_go),
        .sck    (sck),
        .sample (smp)
    );

    sar_shift_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (smp),
        .sdo    (sdo),
        .word   (word_data),
        .valid  (word_valid)
    );

endmodule

// File: rtl/sar_readout_ctrl_chk.sv
// Timing checker for the readout sequencer: measures cycles since the last
// cnv rise and since the last sck fall, and checks the windows against them.
// Assumes: bound to sar_readout_ctrl with that block's parameters.
module sar_readout_ctrl_chk #(
    parameter int unsigned CYC_PERIOD = 125,
    parameter int unsigned CNV_HIGH   = 2,
    parameter int unsigned QUIET1     = 24,
    parameter int unsigned QUIET2     = 8
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic sck,
    input logic word_valid,
    input logic mode
);

    localparam int unsigned SW = $clog2(CYC_PERIOD + 2) + 1;
    localparam logic [SW-1:0] SAT    = {SW{1'b1}};
    localparam logic [SW-1:0] CYC_C  = SW'(CYC_PERIOD);
    localparam logic [SW-1:0] HIGH_C = SW'(CNV_HIGH);
    localparam logic [SW-1:0] Q1_C   = SW'(QUIET1);
    localparam logic [SW-1:0] Q2_C   = SW'(QUIET2);

    logic          cnv_d, sck_d;
    logic [SW-1:0] since_rise, since_fall, hi_len;

    // Saturating distance counters for the window checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_d      <= 1'b0;
            sck_d      <= 1'b0;
            since_rise <= SAT;
            since_fall <= SAT;
            hi_len     <= '0;
        end else begin
            cnv_d      <= cnv;
            sck_d      <= sck;
            since_rise <= (cnv && !cnv_d) ? SW'(1) : ((since_rise == SAT) ? SAT : since_rise + 1'b1);
            since_fall <= (!sck && sck_d) ? SW'(1) : ((since_fall == SAT) ? SAT : since_fall + 1'b1);
            hi_len     <= cnv ? hi_len + 1'b1 : '0;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!cnv && !sck && !word_valid));

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> since_rise >= CYC_C);

    assert_cnv_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> hi_len == (mode ? Q1_C : HIGH_C));

    // R4 and R5: no serial clock rise inside the first quiet window.
    assert_quiet1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> since_rise >= Q1_C);

    assert_sck_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> since_rise < CYC_C);

    assert_quiet2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> since_fall >= Q2_C);

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

endmodule

bind sar_readout_ctrl sar_readout_ctrl_chk #(
    .CYC_PERIOD (CYC_PERIOD),
    .CNV_HIGH   (CNV_HIGH),
    .QUIET1     (QUIET1),
    .QUIET2     (QUIET2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnv        (cnv),
    .sck        (sck),
    .word_valid (word_valid),
    .mode       (tmr_mode)
);

// File: tb/sar_readout_ctrl_tb.sv
// Scoreboard bench: a converter model pushes each expected word when cnv
// rises; the monitor pops and compares on word_valid and times every edge.
module sar_readout_ctrl_tb;

    localparam int W   = 18;
    localparam int CYC = 125;
    localparam int CH  = 2;
    localparam int CWT = 40;
    localparam int Q1  = 24;
    localparam int Q2  = 8;
    localparam int H   = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         turbo = 1'b0;
    logic         sdo = 1'b0;
    logic         cnv, sck, word_valid;
    logic [W-1:0] word_data;

    always #4 clk = ~clk;

    sar_readout_ctrl #(
        .DATA_W(W), .CYC_PERIOD(CYC), .CNV_HIGH(CH), .CONV_WAIT(CWT),
        .QUIET1(Q1), .QUIET2(Q2), .SCK_HALF(H)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .turbo(turbo), .sdo(sdo),
        .cnv(cnv), .sck(sck), .word_valid(word_valid), .word_data(word_data)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [W-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] gen(input int k);
        case (k)
            0: return 18'h3FFFF;
            1: return 18'h00000;
            2: return 18'h2AAAA;
            3: return 18'h15555;
            default: return W'((k * 32'h9E37) ^ (k << 7) ^ 32'h1234);
        endcase
    endfunction

    // Converter model and monitor state.
    int           tcnt = 0, t_rise = 0, t_last_rise = 0, t_sck_fall = 0;
    int           rises = 0, bit_idx = 0, conv_idx = 0, n_rise = 0;
    bit           cnv_p = 0, sck_p = 0, have_rise = 0, rise_mode = 0, burst_due = 0;
    logic [W-1:0] cur_val = '0, out_word = '0;

    // Driver side: a new conversion starts; push the word the readout must return.
    task automatic on_cnv_rise();
        bit consecutive;
        logic [W-1:0] nv;
        int gap;
        consecutive = 0;
        if (have_rise) begin
            gap = tcnt - t_rise;
            consecutive = (gap == CYC);
            if (gap < 2 * CYC) chk(gap == CYC, "R2", "cnv rise spacing", gap, CYC);
            if (burst_due) chk(rises == W, "R7", "sck pulses per readout", rises, W);
            else           chk(rises == 0, "R6", "sck pulses in skipped turbo period", rises, 0);
            if (rises > 0) chk(tcnt - t_sck_fall >= Q2, "R8", "last fall to cnv rise", tcnt - t_sck_fall, Q2);
        end
        nv = gen(conv_idx);
        conv_idx++;
        if (!turbo) begin
            out_word = nv;
            burst_due = 1;
            exp_q.push_back(nv);
        end else begin
            out_word = cur_val;
            burst_due = consecutive && rise_mode;
            if (burst_due) exp_q.push_back(cur_val);
        end
        cur_val = nv;
        rise_mode = turbo;
        t_rise = tcnt;
        rises = 0;
        bit_idx = 0;
        sdo = out_word[W-1];
        have_rise = 1;
        n_rise++;
    endtask

    // Monitor: samples away from the active edge, times edges, scores words.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_rise = 0;
            rises = 0;
            cnv_p = 0;
            sck_p = 0;
            burst_due = 0;
        end else begin
            tcnt++;
            if (cnv && !cnv_p) on_cnv_rise();
            if (!cnv && cnv_p)
                chk(tcnt - t_rise == (rise_mode ? Q1 : CH), "R3", "cnv high cycles",
                    tcnt - t_rise, rise_mode ? Q1 : CH);
            if (sck && !sck_p) begin
                if (rises == 0) begin
                    if (turbo != rise_mode)
                        chk(tcnt - t_rise == (rise_mode ? Q1 : CWT), "R11", "mode change mid-period",
                            tcnt - t_rise, rise_mode ? Q1 : CWT);
                    else if (rise_mode)
                        chk(tcnt - t_rise == Q1, "R5", "turbo first sck rise", tcnt - t_rise, Q1);
                    else
                        chk(tcnt - t_rise == CWT, "R4", "normal first sck rise", tcnt - t_rise, CWT);
                end else begin
                    chk(tcnt - t_last_rise == 2 * H, "R7", "sck period", tcnt - t_last_rise, 2 * H);
                end
                rises++;
                t_last_rise = tcnt;
            end
            if (!sck && sck_p) begin
                chk(tcnt - t_last_rise == H, "R7", "sck high time", tcnt - t_last_rise, H);
                t_sck_fall = tcnt;
                bit_idx++;
                sdo = (bit_idx < W) ? out_word[W-1-bit_idx] : ~sdo;
            end
            if (word_valid) begin
                chk(rises == W && tcnt == t_last_rise, "R10", "valid timing", rises, W);
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected word", word_data, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(word_data[W-1] == e[W-1], "R9", "msb first", word_data[W-1], e[W-1]);
                    chk(word_data == e, rise_mode ? "R5" : "R4", "captured word", word_data, e);
                end
            end
            cnv_p = cnv;
            sck_p = sck;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus sequence.
    initial begin
        int n_snap;
        rst_n = 1'b0;
        wait_cyc(5);
        chk(cnv == 0 && sck == 0 && word_valid == 0, "R1", "reset outputs", {cnv, sck, word_valid}, 0);
        rst_n = 1'b1;
        wait_cyc(50);
        chk(n_rise == 0 && cnv == 0, "R1", "no conversion while disabled", n_rise, 0);

        // Normal mode run.
        enable = 1'b1;
        wait_cyc(4 * CYC + 20);

        // Switch to turbo in the middle of a period.
        @(posedge cnv);
        wait_cyc(10);
        turbo = 1'b1;
        wait_cyc(5 * CYC);

        // Drop enable in the middle of a turbo period.
        @(posedge cnv);
        wait_cyc(10);
        enable = 1'b0;
        n_snap = n_rise;
        wait_cyc(3 * CYC);
        chk(n_rise == n_snap, "R2", "no cnv after enable drop", n_rise, n_snap);
        chk(exp_q.size() == 0, "R2", "last period word delivered", exp_q.size(), 0);

        // Turbo start from idle: first period must skip readout.
        enable = 1'b1;
        wait_cyc(4 * CYC + 10);

        // Reset in the middle of a burst.
        @(posedge sck);
        wait_cyc(3);
        rst_n = 1'b0;
        wait_cyc(3);
        chk(cnv == 0 && sck == 0 && word_valid == 0, "R1", "reset mid-burst", {cnv, sck, word_valid}, 0);
        exp_q.delete();
        turbo = 1'b0;
        rst_n = 1'b1;
        wait_cyc(3 * CYC + 10);
        enable = 1'b0;
        wait_cyc(2 * CYC);
        chk(exp_q.size() == 0, "R4", "all expected words seen", exp_q.size(), 0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

endmodule